// File: doc/BRIEF.md
# Duty-Cycled Low-Supply Status Flag Controller

This block runs a supply-voltage detector on a low duty cycle for a timekeeping device that is clocked at 32.768 kHz. A free-running counter marks a one-second period. At the start of each period the block opens a short sampling window and drives an enable to an external voltage comparator. On the last cycle of the window it takes the comparator's synchronized digital output. If that output shows the supply at or below the detection level, the block sets a sticky low-supply flag.

Once the flag is set, the block opens no more windows. The flag holds its value whatever the supply does afterwards. A host read of the status byte returns the flag and clears it. Sampling then starts again at the next period boundary, never part-way through a period. If the supply is still low in that first window, the flag sets again and sampling stops again. Setting the flag has no effect on any other state. Bringing the rest of the device back to a known state is left to software.

Top module: `lvd_monitor`

## Requirements
- R1: After reset is released, the period counter starts at 0 and counts `PERIOD_CYCLES` cycles per period (32768 by default). A sampling window covers counter values 0 to `WINDOW_CYCLES`-1 (512 by default).
- R2: `compEn` is 1 only on cycles inside a sampling window while sampling is armed. On every other cycle it is 0.
- R3: `compLowIn` passes through a two-flop synchronizer. It is judged only at the clock edge that ends the last cycle of a window. A low level that ends early enough to be gone from the second flop by that edge leaves the flag at 0.
- R4: When the synchronized comparator value is 1 at that edge, the flag is 1 from the next cycle on.
- R5: While the flag is 1, `compEn` stays 0 and the flag stays 1 until a read, whatever `compLowIn` does.
- R6: `statusByte` shows the flag at bit 1, and all other bits are 0. A one-cycle `statusRead` returns the current value and clears the flag at the next edge.
- R7: After the flag is cleared, sampling re-arms only at the next period boundary. `compEn` stays 0 for the rest of the current period.
- R8: A read on the same cycle as a detection leaves the flag at 1.
- R9: In reset the flag is 0, and `statusByte` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz timekeeping clock |
| rstN | input | 1 | Asynchronous reset, active low |
| compLowIn | input | 1 | Comparator output, asynchronous; 1 means the supply is at or below the detection level |
| statusRead | input | 1 | One-cycle pulse when the host reads the status byte |
| compEn | output | 1 | Enable to the comparator, high during an armed sampling window |
| statusByte | output | 8 | Status byte; bit 1 is the low-supply flag |

## Verification
The comparator input is driven per period in three patterns:
- **Steadily high:** shows that nothing is detected.
- **Steadily low:** shows detection, and that sampling halts after it.
- **Low only in the early part of the window:** shows that only the value at the window's end is sampled.

Host reads arrive at random cycles, so some land mid-period. These show that re-arming waits for the period boundary rather than following the clear. A directed read on the exact detection edge separates a design where the set wins from one where the clear wins. Holding the comparator low across a read shows that the flag sets again in the very next window.

// File: rtl/lvd_pkg.sv
package lvd_pkg;
  // Strobes passed from the window control to the flag datapath
  typedef struct packed {
    logic inWindow;   // counter is inside the sampling window
    logic sampleNow;  // armed and on the last cycle of the window
  } lvdStrobe_t;
endpackage

// File: rtl/lvd_ctrl.sv
module lvd_ctrl
  import lvd_pkg::*;
#(
  parameter int PERIOD_CYCLES = 32768,
  parameter int WINDOW_CYCLES = 512
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       flag,
  output lvdStrobe_t strobe,
  output logic       compEn
);
  localparam int CW = $clog2(PERIOD_CYCLES);
  localparam logic [CW-1:0] LAST_CNT = CW'(PERIOD_CYCLES - 1);
  localparam logic [CW-1:0] WIN_LAST = CW'(WINDOW_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          armed;
  logic          wrap;

  assign wrap = (cnt == LAST_CNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      armed <= 1'b1;
    end else begin
      cnt   <= wrap ? '0 : cnt + 1'b1;
      // re-arm only at a period boundary; drop out as soon as the flag is up
      armed <= wrap ? !flag : (armed && !flag);
    end
  end

  always_comb begin
    strobe.inWindow  = (cnt <= WIN_LAST);
    strobe.sampleNow = armed && (cnt == WIN_LAST);
    compEn           = armed && strobe.inWindow;
  end

  // R2: enable only inside the window
  a_r2_en_in_window: assert property (@(posedge clk) disable iff (!rstN)
    compEn |-> (cnt <= WIN_LAST));
  // R5: no enable while the flag is set
  a_r5_no_en_when_flag: assert property (@(posedge clk) disable iff (!rstN)
    flag |-> !compEn);
  // R7: sampling arms only at the start of a period
  a_r7_rearm_at_boundary: assert property (@(posedge clk) disable iff (!rstN)
    $rose(armed) |-> (cnt == '0));
endmodule

// File: rtl/lvd_data.sv
module lvd_data
  import lvd_pkg::*;
#(
  parameter int STATUS_W = 8,
  parameter int FLAG_BIT = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                compLowIn,
  input  logic                statusRead,
  input  lvdStrobe_t          strobe,
  output logic                flag,
  output logic [STATUS_W-1:0] statusByte
);
  logic syncA, syncB;
  logic detect;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
    end else begin
      syncA <= compLowIn;
      syncB <= syncA;
    end
  end

  assign detect = strobe.sampleNow && syncB;

  // set has priority over a concurrent read-clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           flag <= 1'b0;
    else if (detect)     flag <= 1'b1;
    else if (statusRead) flag <= 1'b0;
  end

  always_comb begin
    statusByte           = '0;
    statusByte[FLAG_BIT] = flag;
  end

  // R4: a detection sets the flag
  a_r4_detect_sets: assert property (@(posedge clk) disable iff (!rstN)
    detect |=> flag);
  // R8: a read on the detection cycle does not lose it
  a_r8_read_race: assert property (@(posedge clk) disable iff (!rstN)
    (detect && statusRead) |=> flag);
  // R6: a read without detection clears
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !strobe.sampleNow) |=> !flag);
  // R3: the flag only rises after a sample strobe
  a_r3_set_only_on_sample: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flag) |-> $past(strobe.sampleNow));
  // R5: without a read the flag holds
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !statusRead) |=> flag);
endmodule

// File: rtl/lvd_monitor.sv
module lvd_monitor
  import lvd_pkg::*;
#(
  parameter int PERIOD_CYCLES = 32768,
  parameter int WINDOW_CYCLES = 512
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       compLowIn,
  input  logic       statusRead,
  output logic       compEn,
  output logic [7:0] statusByte
);
  lvdStrobe_t strobe;
  logic       flag;

  lvd_ctrl #(
    .PERIOD_CYCLES(PERIOD_CYCLES),
    .WINDOW_CYCLES(WINDOW_CYCLES)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .flag   (flag),
    .strobe (strobe),
    .compEn (compEn)
  );

  lvd_data #(
    .STATUS_W(8),
    .FLAG_BIT(1)
  ) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .compLowIn  (compLowIn),
    .statusRead (statusRead),
    .strobe     (strobe),
    .flag       (flag),
    .statusByte (statusByte)
  );
endmodule

// File: tb/lvd_monitor_tb.sv
`timescale 1ns/1ps
module lvd_monitor_tb;
  localparam int P = 64;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic compLow = 1'b0;
  logic statusRead = 1'b0;
  logic compEn;
  logic [7:0] statusByte;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference state derived from the requirements
  int   mCnt;
  logic mArmed, mFlag, mS1, mS2;

  always #5 clk = ~clk;

  lvd_monitor #(.PERIOD_CYCLES(P), .WINDOW_CYCLES(W)) u_dut (
    .clk(clk), .rstN(rstN), .compLowIn(compLow), .statusRead(statusRead),
    .compEn(compEn), .statusByte(statusByte)
  );

  function automatic logic expEn(int c, logic a);
    return a && (c < W);
  endfunction

  function automatic logic [7:0] expStatus(logic f);
    return {6'b0, f, 1'b0};
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt <= 0; mArmed <= 1'b1; mFlag <= 1'b0; mS1 <= 1'b0; mS2 <= 1'b0;
    end else begin
      mS1 <= compLow;
      mS2 <= mS1;
      if (mArmed && mCnt == W-1 && mS2) mFlag <= 1'b1;
      else if (statusRead)             mFlag <= 1'b0;
      if (mCnt == P-1) mArmed <= !mFlag;
      else             mArmed <= mArmed && !mFlag;
      mCnt <= (mCnt == P-1) ? 0 : mCnt + 1;
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(mFlag ? "R5" : (!mArmed ? "R7" : (mCnt < W ? "R1" : "R2")),
            {7'b0, compEn}, {7'b0, expEn(mCnt, mArmed)});
      check(mFlag ? "R4/R5 flag" : "R6 flag", statusByte, expStatus(mFlag));
    end
  end

  task automatic waitCnt(int v);
    do @(negedge clk); while (mCnt != v);
  endtask

  task automatic readPulse();
    statusRead = 1'b1;
    @(negedge clk);
    statusRead = 1'b0;
  endtask

  initial begin
    int seedVal;
    int mode;
    seedVal = $urandom(32'h1F2E);
    repeat (3) @(negedge clk);
    check("R9 reset", statusByte, 8'h00);
    rstN = 1'b1;

    // random phase: per-period comparator pattern, random reads
    for (int per = 0; per < 80; per++) begin
      mode = $urandom_range(0, 2);
      for (int c = 0; c < P; c++) begin
        @(negedge clk);
        case (mode)
          0: compLow = 1'b0;
          1: compLow = 1'b1;
          default: compLow = (mCnt < W-4);
        endcase
        statusRead = ($urandom_range(0, 19) == 0);
      end
    end
    statusRead = 1'b0;

    // R3: low only early in the window is ignored
    compLow = 1'b0;
    @(negedge clk);
    if (mFlag) readPulse();
    do @(negedge clk); while (!(mCnt == P-1 && mArmed));
    compLow = 1'b1;
    waitCnt(W-4);
    compLow = 1'b0;
    waitCnt(W);
    check("R3 glitch ignored", statusByte, 8'h00);

    // R4: steady low detected, then R5 stickiness across recovery
    compLow = 1'b1;
    waitCnt(W);
    check("R4 detect", statusByte, 8'h02);
    compLow = 1'b0;
    repeat (3) waitCnt(W/2);
    check("R5 no window", {7'b0, compEn}, 8'h00);
    check("R5 sticky", statusByte, 8'h02);

    // R7: read mid-period, no enable until boundary
    compLow = 1'b1;
    waitCnt(P/2);
    readPulse();
    check("R6 cleared", statusByte, 8'h00);
    check("R7 stays off", {7'b0, compEn}, 8'h00);
    waitCnt(0);
    check("R7 rearm", {7'b0, compEn}, 8'h01);
    waitCnt(W);
    check("R4 re-detect", statusByte, 8'h02);

    // R8: read on the detection edge
    waitCnt(P/2);
    readPulse();
    waitCnt(W-1);
    statusRead = 1'b1;
    @(negedge clk);
    statusRead = 1'b0;
    check("R8 race keeps flag", statusByte, 8'h02);
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule